// File: doc/BRIEF.md
# Overlapping Register Window File

This block is a register file organised as a ring of overlapping windows, with a small bank of global registers that every window can see. Each window is split into three groups of equal size: incoming arguments, private locals, and outgoing arguments. The outgoing group of one window occupies the same physical entries as the incoming group of the window after it. A procedure call therefore hands its arguments to the callee by moving a pointer, and no data is copied.

The current-window pointer (`cwp`) selects the active window. Register numbers are short and relative to the active window, and the block translates them to physical entries itself. The saved-window pointer (`swp`) marks the oldest window still held in the ring. A call that would reuse the storage of that window raises a spill request. A return into a window that has already been spilled raises a fill request. While a request is pending, the pointers hold still. Trap software performs the memory transfer and then pulses the matching acknowledge, which moves `swp` by one window and returns the control state machine to normal operation.

The control state machine has three states. `ST_RUN` is normal operation. `ST_SPILL` means a spill request is pending, and `ST_FILL` means a fill request is pending. Its transitions are:
- CALL_OK: from `ST_RUN` to `ST_RUN`; `cwp` advances by one.
- CALL_OVF: from `ST_RUN` to `ST_SPILL`.
- RET_OK: from `ST_RUN` to `ST_RUN`; `cwp` steps back by one.
- RET_UNF: from `ST_RUN` to `ST_FILL`.
- SPILL_ACK: from `ST_SPILL` to `ST_RUN`; `swp` advances by one.
- FILL_ACK: from `ST_FILL` to `ST_RUN`; `swp` steps back by one.

Top module: `regwin_file`

## Requirements
- R1: A synchronous reset sets `cwp` and `swp` to window 0 and clears both `spill_req` and `fill_req`.
- R2: Register numbers 0 to 7 (top two bits 00) select the global registers. A global holds the same value whichever window is current.
- R3: Register numbers 24 to 31 (top bits 11) are the outgoing arguments. Outgoing register k of window w is the same storage as incoming register k (number 8+k, top bits 01) of window (w+1) mod 8, including the wrap from window 7 to window 0.
- R4: Register numbers 16 to 23 (top bits 10) are locals. Each window has its own locals, and a write to one window's locals leaves every other window's locals unchanged.
- R5: In `ST_RUN`, a call advances `cwp` by one modulo 8 when (`cwp`+2) mod 8 differs from `swp`. A return without a call steps `cwp` back by one modulo 8 when `cwp` differs from `swp`. Each change appears after one clock edge.
- R6: In `ST_RUN`, a call when (`cwp`+2) mod 8 equals `swp` raises `spill_req` after one clock edge and leaves `cwp` unchanged.
- R7: In `ST_SPILL`, `spill_done` advances `swp` by one modulo 8 and clears `spill_req` after one clock edge.
- R8: In `ST_RUN`, a return without a call when `cwp` equals `swp` raises `fill_req` after one clock edge and leaves `cwp` unchanged.
- R9: In `ST_FILL`, `fill_done` steps `swp` back by one modulo 8 and clears `fill_req` after one clock edge.
- R10: While a request is pending, `call` and `ret` have no effect, and an acknowledge that does not match the pending request has no effect. In `ST_RUN`, both acknowledges are ignored. `spill_req` and `fill_req` are never high together.
- R11: A read of the physical entry being written in the same cycle returns the new data. From the next edge on, the entry holds that data.
- R12: When `call` and `ret` are asserted together in `ST_RUN`, the call takes effect and the return is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| call | input | 1 | Procedure call: advance to the next window |
| ret | input | 1 | Procedure return: go back to the previous window |
| spill_done | input | 1 | Trap software has saved the oldest window |
| fill_done | input | 1 | Trap software has restored the previous window |
| we | input | 1 | Write enable |
| waddr | input | 5 | Window-relative write register number |
| wdata | input | 32 | Write data |
| raddr_a | input | 5 | Window-relative register number, read port A |
| raddr_b | input | 5 | Window-relative register number, read port B |
| rdata_a | output | 32 | Read data, port A |
| rdata_b | output | 32 | Read data, port B |
| cwp | output | 3 | Current-window pointer |
| swp | output | 3 | Saved-window pointer |
| spill_req | output | 1 | Overflow trap request (window spill) |
| fill_req | output | 1 | Underflow trap request (window fill) |

## Verification
The bench builds the block with its default parameters: 8 windows, 8 registers per group and 32-bit data. At this size a single run can fill every window in the ring. It takes the pointers around both wrap points, from 7 to 0 on calls and from 0 to 7 on `swp` after a fill. It also reaches overflow and underflow at several different positions of `swp`. Expected pointer values come from modular arithmetic in the bench. Register contents are encoded from the window and register numbers, so each window's locals and each overlap pair can be checked against a value the bench computes.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_SPILL = 2'd1,
        ST_FILL  = 2'd2
    } win_state_t;

    // Register group, taken from the top two bits of a register number
    localparam logic [1:0] GRP_GLOB = 2'd0;
    localparam logic [1:0] GRP_IN   = 2'd1;
    localparam logic [1:0] GRP_LOC  = 2'd2;
    localparam logic [1:0] GRP_OUT  = 2'd3;

endpackage

// File: rtl/regwin_map.sv
module regwin_map
    import regwin_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int NREG = 8,
    localparam int OFF_W = $clog2(NREG),
    localparam int RN_W  = OFF_W + 2,
    localparam int CW    = $clog2(NWIN),
    localparam int NPHYS = NREG + NWIN * 2 * NREG,
    localparam int PW    = $clog2(NPHYS)
) (
    input  logic [CW-1:0]   cwp,
    input  logic [RN_W-1:0] rnum,
    output logic [PW-1:0]   pidx
);

    logic [1:0]       grp;
    logic [OFF_W-1:0] off;
    int               win;
    int               base;
    int               idx_i;

    // Globals sit at 0..NREG-1. Window w owns incoming then local blocks
    // starting at NREG + w*2*NREG. Its outgoing block is the incoming block
    // of window (w+1) mod NWIN.
    always_comb begin
        grp  = rnum[RN_W-1:OFF_W];
        off  = rnum[OFF_W-1:0];
        win  = int'(cwp);
        if (grp == GRP_OUT) begin
            win = (win + 1) % NWIN;
        end
        base = NREG + win * 2 * NREG;
        unique case (grp)
            GRP_GLOB: idx_i = int'(off);
            GRP_IN:   idx_i = base + int'(off);
            GRP_LOC:  idx_i = base + NREG + int'(off);
            default:  idx_i = base + int'(off);
        endcase
        pidx = PW'(idx_i);
    end

endmodule

// File: rtl/regwin_ctrl.sv
module regwin_ctrl
    import regwin_pkg::*;
#(
    parameter int NWIN = 8,
    localparam int CW  = $clog2(NWIN)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          call,
    input  logic          ret,
    input  logic          spill_done,
    input  logic          fill_done,
    output logic [CW-1:0] cwp,
    output logic [CW-1:0] swp,
    output logic          spill_req,
    output logic          fill_req
);

    win_state_t    state, nstate;
    logic [CW-1:0] ncwp, nswp;
    logic          ovf_hit;
    logic          unf_hit;

    // A callee needs the incoming block two windows ahead to be free
    assign ovf_hit = ((cwp + CW'(2)) == swp);
    assign unf_hit = (cwp == swp);

    // State and pointer registers
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_RUN;
            cwp   <= '0;
            swp   <= '0;
        end else begin
            state <= nstate;
            cwp   <= ncwp;
            swp   <= nswp;
        end
    end

    // Transitions: CALL_OK, CALL_OVF, RET_OK, RET_UNF, SPILL_ACK, FILL_ACK
    always_comb begin
        nstate = state;
        ncwp   = cwp;
        nswp   = swp;
        unique case (state)
            ST_RUN: begin
                if (call) begin
                    if (ovf_hit) nstate = ST_SPILL;       // CALL_OVF
                    else         ncwp   = cwp + CW'(1);   // CALL_OK
                end else if (ret) begin
                    if (unf_hit) nstate = ST_FILL;        // RET_UNF
                    else         ncwp   = cwp - CW'(1);   // RET_OK
                end
            end
            ST_SPILL: begin
                if (spill_done) begin                     // SPILL_ACK
                    nswp   = swp + CW'(1);
                    nstate = ST_RUN;
                end
            end
            ST_FILL: begin
                if (fill_done) begin                      // FILL_ACK
                    nswp   = swp - CW'(1);
                    nstate = ST_RUN;
                end
            end
            default: nstate = ST_RUN;
        endcase
    end

    // Output decode
    always_comb begin
        spill_req = (state == ST_SPILL);
        fill_req  = (state == ST_FILL);
    end

    a_r5_call_step: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && call && !ovf_hit) |=> (cwp == $past(cwp) + CW'(1)));

    a_r5_ret_step: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && !call && ret && !unf_hit) |=> (cwp == $past(cwp) - CW'(1)));

    a_r6_overflow_trap: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && call && ovf_hit) |=> (spill_req && $stable(cwp)));

    a_r8_underflow_trap: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && !call && ret && unf_hit) |=> (fill_req && $stable(cwp)));

    a_r10_hold_while_pending: assert property (@(posedge clk) disable iff (rst)
        (spill_req || fill_req) |=> $stable(cwp));

    a_r10_swp_only_on_ack: assert property (@(posedge clk) disable iff (rst)
        (!(spill_req && spill_done) && !(fill_req && fill_done)) |=> $stable(swp));

    a_r7_spill_ack: assert property (@(posedge clk) disable iff (rst)
        (spill_req && spill_done) |=> (!spill_req && swp == $past(swp) + CW'(1)));

    a_r9_fill_ack: assert property (@(posedge clk) disable iff (rst)
        (fill_req && fill_done) |=> (!fill_req && swp == $past(swp) - CW'(1)));

    a_r10_req_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({spill_req, fill_req}));

endmodule

// File: rtl/regwin_store.sv
module regwin_store #(
    parameter int NPHYS = 136,
    parameter int DW    = 32,
    parameter int NRD   = 2,
    localparam int PW   = $clog2(NPHYS)
) (
    input  logic                    clk,
    input  logic                    we,
    input  logic [PW-1:0]           widx,
    input  logic [DW-1:0]           wdata,
    input  logic [NRD-1:0][PW-1:0]  ridx,
    output logic [NRD-1:0][DW-1:0]  rdata
);

    logic [DW-1:0] mem [NPHYS];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[widx] <= wdata;
        end
    end

    // One read port per generate iteration, each forwarding a same-cycle write
    for (genvar p = 0; p < NRD; p++) begin : g_rd
        always_comb begin
            if (we && widx == ridx[p]) rdata[p] = wdata;
            else                       rdata[p] = mem[ridx[p]];
        end
    end

endmodule

// File: rtl/regwin_file.sv
module regwin_file
    import regwin_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int NREG = 8,
    parameter int DW   = 32
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       call,
    input  logic                       ret,
    input  logic                       spill_done,
    input  logic                       fill_done,
    input  logic                       we,
    input  logic [$clog2(NREG)+1:0]    waddr,
    input  logic [DW-1:0]              wdata,
    input  logic [$clog2(NREG)+1:0]    raddr_a,
    input  logic [$clog2(NREG)+1:0]    raddr_b,
    output logic [DW-1:0]              rdata_a,
    output logic [DW-1:0]              rdata_b,
    output logic [$clog2(NWIN)-1:0]    cwp,
    output logic [$clog2(NWIN)-1:0]    swp,
    output logic                       spill_req,
    output logic                       fill_req
);

    localparam int NRD   = 2;
    localparam int RN_W  = $clog2(NREG) + 2;
    localparam int NPHYS = NREG + NWIN * 2 * NREG;
    localparam int PW    = $clog2(NPHYS);

    logic [NRD-1:0][RN_W-1:0] raddr;
    logic [NRD-1:0][PW-1:0]   ridx;
    logic [NRD-1:0][DW-1:0]   rdata;
    logic [PW-1:0]            widx;

    assign raddr[0] = raddr_a;
    assign raddr[1] = raddr_b;
    assign rdata_a  = rdata[0];
    assign rdata_b  = rdata[1];

    regwin_ctrl #(.NWIN(NWIN)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .call       (call),
        .ret        (ret),
        .spill_done (spill_done),
        .fill_done  (fill_done),
        .cwp        (cwp),
        .swp        (swp),
        .spill_req  (spill_req),
        .fill_req   (fill_req)
    );

    regwin_map #(.NWIN(NWIN), .NREG(NREG)) u_wmap (
        .cwp  (cwp),
        .rnum (waddr),
        .pidx (widx)
    );

    for (genvar p = 0; p < NRD; p++) begin : g_rmap
        regwin_map #(.NWIN(NWIN), .NREG(NREG)) u_rmap (
            .cwp  (cwp),
            .rnum (raddr[p]),
            .pidx (ridx[p])
        );
    end

    regwin_store #(.NPHYS(NPHYS), .DW(DW), .NRD(NRD)) u_store (
        .clk   (clk),
        .we    (we),
        .widx  (widx),
        .wdata (wdata),
        .ridx  (ridx),
        .rdata (rdata)
    );

    // R11: a written entry reads back its data on the following cycle
    a_r11_write_visible: assert property (@(posedge clk) disable iff (rst)
        we |=> ((!we && ridx[0] == $past(widx)) ? (rdata[0] == $past(wdata)) : 1'b1));

    // R10: both trap requests are never raised together at the top level
    a_r10_single_request: assert property (@(posedge clk) disable iff (rst)
        !(spill_req && fill_req));

endmodule

// File: tb/regwin_file_tb_top.sv
`timescale 1ns/1ps
module regwin_file_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        call, ret, spill_done, fill_done, we;
    logic [4:0]  waddr, raddr_a, raddr_b;
    logic [31:0] wdata;
    logic [31:0] rdata_a, rdata_b;
    logic [2:0]  cwp, swp;
    logic        spill_req, fill_req;

    int tests  = 0;
    int fails  = 0;
    int ec     = 0;
    int es     = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    regwin_file dut_i (
        .clk(clk), .rst(rst), .call(call), .ret(ret),
        .spill_done(spill_done), .fill_done(fill_done),
        .we(we), .waddr(waddr), .wdata(wdata),
        .raddr_a(raddr_a), .raddr_b(raddr_b),
        .rdata_a(rdata_a), .rdata_b(rdata_b),
        .cwp(cwp), .swp(swp), .spill_req(spill_req), .fill_req(fill_req)
    );

    function automatic logic [31:0] loc_val(int w, int i);
        return 32'h1000_0000 | (w << 8) | i;
    endfunction
    function automatic logic [31:0] out_val(int w, int i);
        return 32'h3000_0000 | (w << 8) | i;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk_state(input string req, input bit sp, input bit fl);
        chk(req, {29'd0, cwp}, ec[31:0]);
        chk(req, {29'd0, swp}, es[31:0]);
        chk(req, {31'd0, spill_req}, {31'd0, sp});
        chk(req, {31'd0, fill_req}, {31'd0, fl});
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        we = 1'b1; waddr = 5'(a); wdata = d;
        tick();
        we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        raddr_a = 5'(a);
        #0.5;
        d = rdata_a;
    endtask

    task automatic pulse(input bit c, input bit r, input bit sd, input bit fd);
        call = c; ret = r; spill_done = sd; fill_done = fd;
        tick();
        call = 0; ret = 0; spill_done = 0; fill_done = 0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        rst = 1'b1; call = 0; ret = 0; spill_done = 0; fill_done = 0;
        we = 0; waddr = 0; wdata = 0; raddr_a = 0; raddr_b = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk_state("R1 reset", 1'b0, 1'b0);

        // R10: acknowledges with no request pending are ignored
        pulse(0, 0, 1, 0);
        chk_state("R10 spill_done in run", 1'b0, 1'b0);
        pulse(0, 0, 0, 1);
        chk_state("R10 fill_done in run", 1'b0, 1'b0);

        // Globals
        for (int i = 0; i < 8; i++) wr(i, 32'hA000_0000 | i);

        // Fill windows 0..6 with locals and outgoing values
        for (int w = 0; w < 7; w++) begin
            if (w > 0) begin
                for (int i = 0; i < 8; i++) begin
                    rd(8 + i, v);
                    chk("R3 overlap", v, out_val(w - 1, i));
                end
            end
            for (int i = 0; i < 8; i++) begin
                wr(16 + i, loc_val(w, i));
                wr(24 + i, out_val(w, i));
            end
            if (w < 6) begin
                pulse(1, 0, 0, 0);
                ec = (ec + 1) % 8;
                chk_state("R5 call", 1'b0, 1'b0);
            end
        end

        // R6: overflow at cwp=6, swp=0
        pulse(1, 0, 0, 0);
        chk_state("R6 overflow", 1'b1, 1'b0);
        pulse(1, 0, 0, 0);
        chk_state("R10 call while spill", 1'b1, 1'b0);
        pulse(0, 1, 0, 0);
        chk_state("R10 ret while spill", 1'b1, 1'b0);
        pulse(0, 0, 0, 1);
        chk_state("R10 fill_done while spill", 1'b1, 1'b0);
        pulse(0, 0, 1, 0);
        es = (es + 1) % 8;
        chk_state("R7 spill ack", 1'b0, 1'b0);

        pulse(1, 0, 0, 0);
        ec = (ec + 1) % 8;
        chk_state("R5 call after spill", 1'b0, 1'b0);
        for (int i = 0; i < 8; i++) begin
            wr(16 + i, loc_val(7, i));
            wr(24 + i, out_val(7, i));
        end

        pulse(1, 0, 0, 0);
        chk_state("R6 overflow second", 1'b1, 1'b0);
        pulse(0, 0, 1, 0);
        es = (es + 1) % 8;
        chk_state("R7 spill ack second", 1'b0, 1'b0);
        pulse(1, 0, 0, 0);
        ec = (ec + 1) % 8;
        chk_state("R5 call wrap to 0", 1'b0, 1'b0);

        for (int i = 0; i < 8; i++) begin
            rd(8 + i, v);
            chk("R3 overlap wrap", v, out_val(7, i));
            rd(i, v);
            chk("R2 global", v, 32'hA000_0000 | i);
        end

        // Walk back, checking each window's locals
        for (int w = 7; w >= 2; w--) begin
            pulse(0, 1, 0, 0);
            ec = (ec + 7) % 8;
            chk_state("R5 return", 1'b0, 1'b0);
            for (int i = 0; i < 8; i++) begin
                rd(16 + i, v);
                chk("R4 locals", v, loc_val(w, i));
            end
        end

        for (int w = 1; w >= 0; w--) begin
            pulse(0, 1, 0, 0);
            chk_state("R8 underflow", 1'b0, 1'b1);
            pulse(0, 0, 1, 0);
            chk_state("R10 spill_done while fill", 1'b0, 1'b1);
            pulse(0, 0, 0, 1);
            es = (es + 7) % 8;
            chk_state("R9 fill ack", 1'b0, 1'b0);
            pulse(0, 1, 0, 0);
            ec = (ec + 7) % 8;
            chk_state("R5 return after fill", 1'b0, 1'b0);
            for (int i = 0; i < 8; i++) begin
                rd(16 + i, v);
                chk("R4 locals restored", v, loc_val(w, i));
            end
        end

        pulse(0, 1, 0, 0);
        chk_state("R8 underflow at 0", 1'b0, 1'b1);
        pulse(0, 0, 0, 1);
        es = (es + 7) % 8;
        chk_state("R9 fill ack wrap", 1'b0, 1'b0);

        // R11: same-cycle forwarding on both ports, then persistence
        we = 1'b1; waddr = 5'd19; wdata = 32'hDEAD_BEEF;
        raddr_a = 5'd19; raddr_b = 5'd19;
        #0.5;
        chk("R11 bypass a", rdata_a, 32'hDEAD_BEEF);
        chk("R11 bypass b", rdata_b, 32'hDEAD_BEEF);
        tick();
        we = 1'b0;
        #0.5;
        chk("R11 stored", rdata_a, 32'hDEAD_BEEF);

        // R12: call wins over return
        pulse(1, 1, 0, 0);
        ec = (ec + 1) % 8;
        chk_state("R12 call priority", 1'b0, 1'b0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule